// File: doc/BRIEF.md
# Power-Up and Wake-Up Sequencer

This block brings a low-power chip out of a fully unpowered state and hands it to a running operating mode. It runs in the always-on domain. While it waits it watches one wake pin that is active high and six that are active low. On the first active level it enables the core regulator. It waits until the regulator reports good voltage and the oscillator reports stable. It then holds the processor in reset while it copies the fuse bank into a shadow register and writes zero into every SRAM word. Only after that does it release the processor reset.

After release the block spends one cycle checking the wake source, with the watchdog enabled. A valid wake needs at least one latched pin event. An internal restart request (watchdog, external or brown-out) reruns hardware initialization and clears the latched events, so such a restart with no wake pin still active returns the chip to off. The firmware side then reports a configuration result. On success the block enters the run state and presents a 2-bit start mode, plus a polling-table start index when the mode is Polling. On failure it parks in an error state: the system-error flag is set, the watchdog is disabled and host serial access stays enabled.

States: ST_OFF, ST_PWR_UP, ST_FUSE_RD, ST_SRAM_CLR, ST_WAKE_CHK, ST_CFG_WAIT, ST_RUN, ST_ERR. Transitions:
- OFF→PWR_UP on any latched wake event.
- PWR_UP→FUSE_RD when regulator-good and oscillator-ready are both high.
- FUSE_RD→SRAM_CLR on fuse-read done.
- SRAM_CLR→WAKE_CHK on clear done.
- WAKE_CHK→CFG_WAIT when a wake event is latched, and WAKE_CHK→OFF when none is.
- CFG_WAIT→RUN on configuration done with success, and CFG_WAIT→ERR on configuration done with failure.
- Any of PWR_UP, FUSE_RD, SRAM_CLR, WAKE_CHK, CFG_WAIT or RUN goes to PWR_UP on a restart request.
- ERR is left only by the supply reset.

Top module: `pwr_seq_top`

## Requirements
- R1: After the supply reset the block is in ST_OFF. reg_en, cpu_rst_n, host_en, wdt_en, sys_err and mode_valid are all 0, and they stay 0 while no wake pin is active.
- R2: A wake event is pon_hi high or any pon_lo_n bit low. An event lasting one clock period is latched. wake_src reports the latch while the processor is out of reset: bit 0 is pon_hi and bit k (1..6) is pon_lo_n[k-1].
- R3: reg_en rises after a wake event. No fuse read starts until reg_good and osc_ready are both high.
- R4: cpu_rst_n stays low from the rise of reg_en until after the last SRAM clear write. No fuse read or SRAM write happens while cpu_rst_n is high.
- R5: The fuse bank is read at word addresses 0 to FUSE_WORDS-1 in ascending order, one per clock, with data returned one clock after fuse_rd. fuse_q holds word k at bits [k*FUSE_W +: FUSE_W].
- R6: Only after the last fuse word has been read, every SRAM address 0 to SRAM_DEPTH-1 is written once with 0, in ascending order, one per clock.
- R7: The cycle after the processor reset is released is a single wake-check cycle with wdt_en high. If no wake event is latched, the block returns to ST_OFF. Otherwise wdt_en drops and the block waits for cfg_done.
- R8: A sys_rst_req pulse in any powered state other than ST_ERR clears the latched wake events and reruns hardware initialization. With no wake pin still active the block ends in ST_OFF with reg_en low. With a pin still active it reaches the wake check again and accepts the wake.
- R9: On cfg_done with cfg_ok high, mode_valid rises and mode equals cfg_start_mode (0 IDLE, 1 TX, 2 RX, 3 Polling), held constant while running.
- R10: poll_idx equals cfg_poll_base when mode is 3 (Polling) and is 0 for every other mode.
- R11: On cfg_done with cfg_ok low, sys_err is set, wdt_en is 0, mode_valid is 0, and host_en and cpu_rst_n are 1. This state is kept even through later sys_rst_req and cfg_done pulses.
- R12: host_en is 1 whenever the processor is out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on domain clock |
| rst_n | input | 1 | Supply-connect reset, active low |
| pon_hi | input | 1 | Wake pin, active high |
| pon_lo_n | input | N_LO_PINS | Wake pins, active low |
| reg_good | input | 1 | Core regulator at operating voltage |
| osc_ready | input | 1 | Oscillator stable |
| fuse_rdata | input | FUSE_W | Fuse word, valid one clock after fuse_rd |
| cfg_done | input | 1 | Configuration finished (firmware side) |
| cfg_ok | input | 1 | Configuration succeeded, qualified by cfg_done |
| cfg_start_mode | input | 2 | Requested start mode |
| cfg_poll_base | input | 4 | Polling table start index |
| sys_rst_req | input | 1 | Restart from watchdog, external or brown-out reset |
| reg_en | output | 1 | Core regulator enable |
| fuse_rd | output | 1 | Fuse read strobe |
| fuse_addr | output | FUSE_AW | Fuse word address |
| fuse_q | output | FUSE_WORDS*FUSE_W | Fuse shadow |
| sram_we | output | 1 | SRAM write enable |
| sram_addr | output | SRAM_AW | SRAM write address |
| sram_wdata | output | SRAM_DW | SRAM write data |
| cpu_rst_n | output | 1 | Processor reset, active low |
| wdt_en | output | 1 | Watchdog enable |
| host_en | output | 1 | Host serial access enable |
| sys_err | output | 1 | System error flag |
| mode_valid | output | 1 | Start mode valid (running) |
| mode | output | 2 | Active start mode |
| poll_idx | output | 4 | Polling start index |
| wake_src | output | N_LO_PINS+1 | Latched wake sources |

## Verification
Every one of the seven wake pins is used as the wake source. Each is applied either as a one-clock pulse or held through the wake check, which separates a latched event from a level that is merely present. All four start modes are swept against all sixteen polling base values, which shows that the index passes through only in Polling mode. Restart requests are sent with the wake pin released and with it held: the first must end in off and the second must come back up, which separates clearing the latch from a plain reinitialization. A failed configuration followed by restart and done pulses shows that the error state is terminal. Throughout, the fuse and SRAM address sequences, zero write data, and the ordering against the processor reset are tracked, while the supply gates are raised one at a time.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    localparam int POLL_W = 4;
    localparam int MODE_W = 2;

    typedef enum logic [2:0] {
        ST_OFF      = 3'd0,
        ST_PWR_UP   = 3'd1,
        ST_FUSE_RD  = 3'd2,
        ST_SRAM_CLR = 3'd3,
        ST_WAKE_CHK = 3'd4,
        ST_CFG_WAIT = 3'd5,
        ST_RUN      = 3'd6,
        ST_ERR      = 3'd7
    } seq_state_t;

    typedef enum logic [MODE_W-1:0] {
        SM_IDLE = 2'd0,
        SM_TX   = 2'd1,
        SM_RX   = 2'd2,
        SM_POLL = 2'd3
    } start_mode_t;

endpackage

// File: rtl/pwr_seq_wake.sv
// Wake pin synchronizers and sticky event latch (one bit per pin).
module pwr_seq_wake #(
    parameter int N_LO_PINS = 6,
    localparam int WAKE_W = N_LO_PINS + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pon_hi,
    input  logic [N_LO_PINS-1:0] pon_lo_n,
    input  logic                 clr,
    output logic [WAKE_W-1:0]    wake_lat,
    output logic                 wake_any
);

    logic [WAKE_W-1:0] raw;
    logic [WAKE_W-1:0] active;
    logic [WAKE_W-1:0] lat_q;

    assign raw = {pon_lo_n, pon_hi};

    // two-stage synchronizer per pin; idle level differs by polarity
    for (genvar i = 0; i < WAKE_W; i++) begin : g_sync
        localparam logic IDLE_LVL = (i == 0) ? 1'b0 : 1'b1;
        logic s1, s2;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1 <= IDLE_LVL;
                s2 <= IDLE_LVL;
            end else begin
                s1 <= raw[i];
                s2 <= s1;
            end
        end
        assign active[i] = s2 ^ IDLE_LVL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else if (clr) begin
            lat_q <= '0;
        end else begin
            lat_q <= lat_q | active;
        end
    end

    assign wake_lat = lat_q;
    assign wake_any = |lat_q;

endmodule

// File: rtl/pwr_seq_fuse.sv
// Sequential fuse bank reader with one-cycle read latency.
module pwr_seq_fuse #(
    parameter int FUSE_WORDS = 4,
    parameter int FUSE_W     = 8,
    localparam int FUSE_AW   = (FUSE_WORDS > 1) ? $clog2(FUSE_WORDS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic                         abort,
    input  logic [FUSE_W-1:0]            rdata,
    output logic                         rd,
    output logic [FUSE_AW-1:0]           addr,
    output logic                         done,
    output logic [FUSE_WORDS*FUSE_W-1:0] fuse_q
);

    localparam logic [FUSE_AW-1:0] LAST = FUSE_AW'(FUSE_WORDS - 1);

    logic                busy_q;
    logic [FUSE_AW-1:0]  addr_q;
    logic                rd_d;
    logic [FUSE_AW-1:0]  addr_d;
    logic                done_q;
    logic [FUSE_W-1:0]   words [FUSE_WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            addr_q <= '0;
            rd_d   <= 1'b0;
            addr_d <= '0;
            done_q <= 1'b0;
        end else if (abort) begin
            busy_q <= 1'b0;
            addr_q <= '0;
            rd_d   <= 1'b0;
            done_q <= 1'b0;
        end else begin
            rd_d   <= busy_q;
            addr_d <= addr_q;
            done_q <= rd_d && (addr_d == LAST);
            if (start) begin
                busy_q <= 1'b1;
                addr_q <= '0;
            end else if (busy_q) begin
                if (addr_q == LAST) begin
                    busy_q <= 1'b0;
                end else begin
                    addr_q <= addr_q + FUSE_AW'(1);
                end
            end
        end
    end

    for (genvar k = 0; k < FUSE_WORDS; k++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                words[k] <= '0;
            end else if (rd_d && !abort && (addr_d == FUSE_AW'(k))) begin
                words[k] <= rdata;
            end
        end
        assign fuse_q[k*FUSE_W +: FUSE_W] = words[k];
    end

    assign rd   = busy_q;
    assign addr = addr_q;
    assign done = done_q;

endmodule

// File: rtl/pwr_seq_sram_clr.sv
// Walks every SRAM address once, writing zero, one word per clock.
module pwr_seq_sram_clr #(
    parameter int SRAM_DEPTH = 256,
    parameter int SRAM_DW    = 8,
    localparam int SRAM_AW   = (SRAM_DEPTH > 1) ? $clog2(SRAM_DEPTH) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               abort,
    output logic               we,
    output logic [SRAM_AW-1:0] addr,
    output logic [SRAM_DW-1:0] wdata,
    output logic               done
);

    localparam logic [SRAM_AW-1:0] LAST = SRAM_AW'(SRAM_DEPTH - 1);

    logic               busy_q;
    logic [SRAM_AW-1:0] addr_q;
    logic               done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            addr_q <= '0;
            done_q <= 1'b0;
        end else if (abort) begin
            busy_q <= 1'b0;
            addr_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= busy_q && (addr_q == LAST);
            if (start) begin
                busy_q <= 1'b1;
                addr_q <= '0;
            end else if (busy_q) begin
                if (addr_q == LAST) begin
                    busy_q <= 1'b0;
                end else begin
                    addr_q <= addr_q + SRAM_AW'(1);
                end
            end
        end
    end

    assign we    = busy_q;
    assign addr  = addr_q;
    assign wdata = '0;
    assign done  = done_q;

endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
    import pwr_seq_pkg::*;
#(
    parameter int N_LO_PINS  = 6,
    parameter int FUSE_WORDS = 4,
    parameter int FUSE_W     = 8,
    parameter int SRAM_DEPTH = 256,
    parameter int SRAM_DW    = 8,
    localparam int FUSE_AW   = (FUSE_WORDS > 1) ? $clog2(FUSE_WORDS) : 1,
    localparam int SRAM_AW   = (SRAM_DEPTH > 1) ? $clog2(SRAM_DEPTH) : 1,
    localparam int WAKE_W    = N_LO_PINS + 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         pon_hi,
    input  logic [N_LO_PINS-1:0]         pon_lo_n,
    input  logic                         reg_good,
    input  logic                         osc_ready,
    input  logic [FUSE_W-1:0]            fuse_rdata,
    input  logic                         cfg_done,
    input  logic                         cfg_ok,
    input  logic [MODE_W-1:0]            cfg_start_mode,
    input  logic [POLL_W-1:0]            cfg_poll_base,
    input  logic                         sys_rst_req,
    output logic                         reg_en,
    output logic                         fuse_rd,
    output logic [FUSE_AW-1:0]           fuse_addr,
    output logic [FUSE_WORDS*FUSE_W-1:0] fuse_q,
    output logic                         sram_we,
    output logic [SRAM_AW-1:0]           sram_addr,
    output logic [SRAM_DW-1:0]           sram_wdata,
    output logic                         cpu_rst_n,
    output logic                         wdt_en,
    output logic                         host_en,
    output logic                         sys_err,
    output logic                         mode_valid,
    output logic [MODE_W-1:0]            mode,
    output logic [POLL_W-1:0]            poll_idx,
    output logic [WAKE_W-1:0]            wake_src
);

    seq_state_t         state_q, state_d;
    logic               abort;
    logic               supply_ok;
    logic               fuse_start, fuse_done;
    logic               clr_start, clr_done;
    logic [WAKE_W-1:0]  wake_lat;
    logic               wake_any;
    start_mode_t        mode_q;
    logic [POLL_W-1:0]  idx_q;

    assign supply_ok = reg_good && osc_ready;
    // restart request is honoured in every powered state except the error park
    assign abort      = sys_rst_req && (state_q != ST_OFF) && (state_q != ST_ERR);
    assign fuse_start = (state_q == ST_PWR_UP) && supply_ok && !abort;
    assign clr_start  = (state_q == ST_FUSE_RD) && fuse_done && !abort;

    pwr_seq_wake #(
        .N_LO_PINS (N_LO_PINS)
    ) wake_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pon_hi   (pon_hi),
        .pon_lo_n (pon_lo_n),
        .clr      (abort),
        .wake_lat (wake_lat),
        .wake_any (wake_any)
    );

    pwr_seq_fuse #(
        .FUSE_WORDS (FUSE_WORDS),
        .FUSE_W     (FUSE_W)
    ) fuse_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (fuse_start),
        .abort  (abort),
        .rdata  (fuse_rdata),
        .rd     (fuse_rd),
        .addr   (fuse_addr),
        .done   (fuse_done),
        .fuse_q (fuse_q)
    );

    pwr_seq_sram_clr #(
        .SRAM_DEPTH (SRAM_DEPTH),
        .SRAM_DW    (SRAM_DW)
    ) clr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (clr_start),
        .abort (abort),
        .we    (sram_we),
        .addr  (sram_addr),
        .wdata (sram_wdata),
        .done  (clr_done)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (abort) begin
            state_d = ST_PWR_UP;
        end else begin
            unique case (state_q)
                ST_OFF:      if (wake_any)  state_d = ST_PWR_UP;
                ST_PWR_UP:   if (supply_ok) state_d = ST_FUSE_RD;
                ST_FUSE_RD:  if (fuse_done) state_d = ST_SRAM_CLR;
                ST_SRAM_CLR: if (clr_done)  state_d = ST_WAKE_CHK;
                ST_WAKE_CHK: state_d = wake_any ? ST_CFG_WAIT : ST_OFF;
                ST_CFG_WAIT: if (cfg_done)  state_d = cfg_ok ? ST_RUN : ST_ERR;
                ST_RUN:      state_d = ST_RUN;
                ST_ERR:      state_d = ST_ERR;
                default:     state_d = ST_OFF;
            endcase
        end
    end

    // start mode capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= SM_IDLE;
            idx_q  <= '0;
        end else if ((state_q == ST_CFG_WAIT) && cfg_done && cfg_ok && !abort) begin
            mode_q <= start_mode_t'(cfg_start_mode);
            idx_q  <= (start_mode_t'(cfg_start_mode) == SM_POLL) ? cfg_poll_base : '0;
        end
    end

    // state-decoded outputs
    always_comb begin
        reg_en     = 1'b0;
        cpu_rst_n  = 1'b0;
        wdt_en     = 1'b0;
        host_en    = 1'b0;
        sys_err    = 1'b0;
        mode_valid = 1'b0;
        unique case (state_q)
            ST_OFF: begin
            end
            ST_PWR_UP, ST_FUSE_RD, ST_SRAM_CLR: begin
                reg_en = 1'b1;
            end
            ST_WAKE_CHK: begin
                reg_en    = 1'b1;
                cpu_rst_n = 1'b1;
                wdt_en    = 1'b1;
                host_en   = 1'b1;
            end
            ST_CFG_WAIT: begin
                reg_en    = 1'b1;
                cpu_rst_n = 1'b1;
                host_en   = 1'b1;
            end
            ST_RUN: begin
                reg_en     = 1'b1;
                cpu_rst_n  = 1'b1;
                host_en    = 1'b1;
                mode_valid = 1'b1;
            end
            ST_ERR: begin
                reg_en    = 1'b1;
                cpu_rst_n = 1'b1;
                host_en   = 1'b1;
                sys_err   = 1'b1;
            end
            default: begin
            end
        endcase
    end

    assign mode     = mode_valid ? mode_q : '0;
    assign poll_idx = mode_valid ? idx_q : '0;
    assign wake_src = cpu_rst_n ? wake_lat : '0;

endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk #(
    parameter int SRAM_AW = 8,
    parameter int SRAM_DW = 8,
    parameter int WAKE_W  = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_en,
    input logic               fuse_rd,
    input logic               sram_we,
    input logic [SRAM_AW-1:0] sram_addr,
    input logic               cpu_rst_n,
    input logic               wdt_en,
    input logic               host_en,
    input logic               sys_err,
    input logic               mode_valid,
    input logic [1:0]         mode,
    input logic [3:0]         poll_idx,
    input logic [WAKE_W-1:0]  wake_src
);

    // R1
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_en |-> (!cpu_rst_n && !sram_we && !fuse_rd && !mode_valid));

    // R4
    rst_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_we || fuse_rd) |-> !cpu_rst_n);

    // R6
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_we && $past(sram_we)) |-> (sram_addr == SRAM_AW'($past(sram_addr) + 1'b1)));

    // R6
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sram_we && fuse_rd));

    // R7
    wake_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_rst_n) |-> wdt_en);

    // R11
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_err |=> (sys_err && !wdt_en && host_en && !mode_valid));

    // R9
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_valid && $past(mode_valid)) |-> $stable(mode));

    // R10
    idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_valid && (mode != 2'd3)) |-> (poll_idx == 4'd0));

    // R2
    run_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_valid |-> (wake_src != '0));

endmodule

bind pwr_seq_top pwr_seq_chk #(
    .SRAM_AW (SRAM_AW),
    .SRAM_DW (SRAM_DW),
    .WAKE_W  (WAKE_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_en     (reg_en),
    .fuse_rd    (fuse_rd),
    .sram_we    (sram_we),
    .sram_addr  (sram_addr),
    .cpu_rst_n  (cpu_rst_n),
    .wdt_en     (wdt_en),
    .host_en    (host_en),
    .sys_err    (sys_err),
    .mode_valid (mode_valid),
    .mode       (mode),
    .poll_idx   (poll_idx),
    .wake_src   (wake_src)
);

// File: tb/pwr_seq_top_tb.sv
`timescale 1ns/1ps
module pwr_seq_top_tb_top;

    localparam int NLO   = 6;
    localparam int FW    = 4;
    localparam int FWID  = 8;
    localparam int DEPTH = 16;
    localparam int FAW   = 2;
    localparam int SAW   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pon_hi = 1'b0;
    logic [NLO-1:0] pon_lo_n = '1;
    logic reg_good = 1'b0, osc_ready = 1'b0;
    logic [FWID-1:0] fuse_rdata = '0;
    logic cfg_done = 1'b0, cfg_ok = 1'b0;
    logic [1:0] cfg_start_mode = '0;
    logic [3:0] cfg_poll_base = '0;
    logic sys_rst_req = 1'b0;

    logic reg_en, fuse_rd, sram_we, cpu_rst_n, wdt_en, host_en, sys_err, mode_valid;
    logic [FAW-1:0] fuse_addr;
    logic [FW*FWID-1:0] fuse_q;
    logic [SAW-1:0] sram_addr;
    logic [7:0] sram_wdata;
    logic [1:0] mode;
    logic [3:0] poll_idx;
    logic [NLO:0] wake_src;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    pwr_seq_top #(
        .N_LO_PINS (NLO), .FUSE_WORDS (FW), .FUSE_W (FWID),
        .SRAM_DEPTH (DEPTH), .SRAM_DW (8)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .pon_hi (pon_hi), .pon_lo_n (pon_lo_n),
        .reg_good (reg_good), .osc_ready (osc_ready), .fuse_rdata (fuse_rdata),
        .cfg_done (cfg_done), .cfg_ok (cfg_ok), .cfg_start_mode (cfg_start_mode),
        .cfg_poll_base (cfg_poll_base), .sys_rst_req (sys_rst_req),
        .reg_en (reg_en), .fuse_rd (fuse_rd), .fuse_addr (fuse_addr), .fuse_q (fuse_q),
        .sram_we (sram_we), .sram_addr (sram_addr), .sram_wdata (sram_wdata),
        .cpu_rst_n (cpu_rst_n), .wdt_en (wdt_en), .host_en (host_en),
        .sys_err (sys_err), .mode_valid (mode_valid), .mode (mode),
        .poll_idx (poll_idx), .wake_src (wake_src)
    );

    function automatic logic [FWID-1:0] fuse_val(int a);
        return 8'h3C ^ 8'(a * 29);
    endfunction

    // synchronous fuse bank model
    always @(posedge clk) begin
        if (fuse_rd) fuse_rdata <= fuse_val(int'(fuse_addr));
    end

    // monitor: sampled at the falling edge
    int n_fuse = 0, n_sram = 0, n_wdt = 0;
    int err_r4 = 0, err_r5 = 0, err_r6 = 0;
    int rf = 0, rs = 0;
    logic p_cpu = 1'b0, p_reg = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if ((p_cpu && !cpu_rst_n) || (!p_reg && reg_en)) begin
                rf = 0;
                rs = 0;
            end
            if (fuse_rd) begin
                if (int'(fuse_addr) != rf || cpu_rst_n) err_r5++;
                rf++;
                n_fuse++;
            end
            if (sram_we) begin
                if (int'(sram_addr) != rs || sram_wdata != 8'h00 || rf < FW) err_r6++;
                if (cpu_rst_n) err_r4++;
                rs++;
                n_sram++;
            end
            if (!p_cpu && cpu_rst_n && rs != DEPTH) err_r4++;
            if (reg_en && !p_reg && cpu_rst_n) err_r4++;
            if (wdt_en) n_wdt++;
            p_cpu = cpu_rst_n;
            p_reg = reg_en;
        end else begin
            p_cpu = 1'b0;
            p_reg = 1'b0;
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic zero_cnt();
        n_fuse = 0; n_sram = 0; n_wdt = 0;
        err_r4 = 0; err_r5 = 0; err_r6 = 0;
    endtask

    task automatic set_pin(input int idx, input bit on);
        if (idx == 0) pon_hi = on;
        else pon_lo_n[idx-1] = ~on;
    endtask

    // supply reset, wake on pin idx, bring up to the wake-check cycle
    task automatic start_run(input int idx, input bit hold);
        logic [FW*FWID-1:0] exp_q;
        rst_n = 1'b0; pon_hi = 1'b0; pon_lo_n = '1;
        reg_good = 1'b0; osc_ready = 1'b0; cfg_done = 1'b0; sys_rst_req = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        zero_cnt();
        repeat (5) step();
        // R1 off after supply reset
        chk(!reg_en && !cpu_rst_n && !host_en && !wdt_en && !sys_err && !mode_valid,
            "R1", "off state outputs",
            {reg_en, cpu_rst_n, host_en, wdt_en, sys_err, mode_valid}, 0);
        set_pin(idx, 1'b1);
        step();
        if (!hold) set_pin(idx, 1'b0);
        for (int k = 0; k < 10 && !reg_en; k++) step();
        chk(reg_en == 1'b1, "R3", "regulator enabled after wake", reg_en, 1);
        reg_good = 1'b1; osc_ready = 1'b0;
        repeat (4) step();
        reg_good = 1'b0; osc_ready = 1'b1;
        repeat (4) step();
        // R3 gate needs both indications
        chk(n_fuse == 0 && !cpu_rst_n, "R3", "no fuse read before supply ok", n_fuse, 0);
        reg_good = 1'b1;
        for (int k = 0; k < 200 && !cpu_rst_n; k++) step();
        chk(wdt_en && host_en, "R7", "wake check window wdt/host", {wdt_en, host_en}, 3);
        chk(wake_src == (NLO+1)'(1 << idx), "R2", "wake source bit", wake_src, 1 << idx);
        chk(n_fuse == FW && err_r5 == 0, "R5", "fuse read order", err_r5, 0);
        exp_q = '0;
        for (int k = 0; k < FW; k++) exp_q[k*FWID +: FWID] = fuse_val(k);
        chk(fuse_q == exp_q, "R5", "fuse shadow", fuse_q, exp_q);
        chk(n_sram == DEPTH && err_r6 == 0, "R6", "sram clear sweep", n_sram, DEPTH);
        chk(err_r4 == 0, "R4", "reset held through init", err_r4, 0);
        step();
        chk(!wdt_en && cpu_rst_n && reg_en, "R7", "valid wake waits for config",
            {wdt_en, cpu_rst_n, reg_en}, 3);
    endtask

    task automatic finish_cfg(input int m, input int b, input bit ok);
        cfg_start_mode = 2'(m); cfg_poll_base = 4'(b); cfg_ok = ok; cfg_done = 1'b1;
        for (int k = 0; k < 5 && !mode_valid && !sys_err; k++) step();
        cfg_done = 1'b0;
    endtask

    initial begin
        // mode x poll-base sweep, rotating wake source, pulse vs held pin
        for (int m = 0; m < 4; m++) begin
            for (int b = 0; b < 16; b++) begin
                int pin;
                int exp_idx;
                pin = (m * 16 + b) % 7;
                start_run(pin, b[0]);
                finish_cfg(m, b, 1'b1);
                exp_idx = (m == 3) ? b : 0;
                chk(mode_valid && int'(mode) == m, "R9", "start mode", mode, m);
                chk(int'(poll_idx) == exp_idx, "R10", "polling index", poll_idx, exp_idx);
                chk(host_en && !sys_err, "R12", "host access while running",
                    {host_en, sys_err}, 2);
                repeat (3) step();
                chk(int'(mode) == m, "R9", "mode held", mode, m);
            end
        end

        // R2 every pin as a one-clock pulse
        for (int p = 0; p < 7; p++) begin
            start_run(p, 1'b0);
            finish_cfg(2, 5, 1'b1);
            chk(wake_src == (NLO+1)'(1 << p), "R2", "pulse latched in run", wake_src, 1 << p);
        end

        // R8 restart with pin released -> off
        start_run(3, 1'b0);
        zero_cnt();
        sys_rst_req = 1'b1; step(); sys_rst_req = 1'b0;
        for (int k = 0; k < 300 && reg_en; k++) step();
        chk(!reg_en && !cpu_rst_n, "R8", "restart without pin returns off",
            {reg_en, cpu_rst_n}, 0);
        chk(n_sram == DEPTH && n_wdt == 1, "R8", "reinit and one wake check", n_sram, DEPTH);
        repeat (10) step();
        chk(!reg_en && !mode_valid, "R8", "stays off", reg_en, 0);

        // R8 restart from run with pin held -> back up
        start_run(5, 1'b1);
        finish_cfg(1, 0, 1'b1);
        chk(int'(mode) == 1, "R9", "tx before restart", mode, 1);
        sys_rst_req = 1'b1; step(); sys_rst_req = 1'b0;
        chk(!cpu_rst_n && !mode_valid, "R8", "restart drops processor",
            {cpu_rst_n, mode_valid}, 0);
        for (int k = 0; k < 300 && !cpu_rst_n; k++) step();
        chk(cpu_rst_n && wake_src == 7'b0100000, "R8", "held pin accepted again",
            wake_src, 7'b0100000);
        step();
        finish_cfg(2, 9, 1'b1);
        chk(mode_valid && mode == 2'd2 && poll_idx == 4'd0, "R8", "rx after restart", mode, 2);
        set_pin(5, 1'b0);

        // R11 configuration failure parks
        start_run(1, 1'b0);
        finish_cfg(0, 0, 1'b0);
        chk(sys_err && !wdt_en && !mode_valid && host_en && cpu_rst_n, "R11", "error park",
            {sys_err, wdt_en, mode_valid, host_en, cpu_rst_n}, 5'b10011);
        zero_cnt();
        sys_rst_req = 1'b1; step(); sys_rst_req = 1'b0;
        cfg_ok = 1'b1; cfg_done = 1'b1; step(); cfg_done = 1'b0;
        repeat (20) step();
        chk(sys_err && host_en && !mode_valid && n_sram == 0 && n_wdt == 0, "R11",
            "error is terminal", {sys_err, host_en, mode_valid}, 3'b110);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule